// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a 32-bit seconds and 31-bit nanoseconds time-of-day value for IEEE 1588 timestamping. It runs in the PTP reference clock domain. Every cycle the counter may advance by a programmable sub-second step. In coarse mode the step is applied on every clock. In fine mode a 32-bit frequency word is added to a 32-bit phase accumulator, and the step is applied only on the cycles where that sum carries out. This lets software trim the counter rate in fractions of a step. The nanoseconds field wraps either at one billion, where one unit is one nanosecond, or at 2^31, where one unit is roughly 0.466 ns. Each wrap carries into the seconds field in the same cycle.

Software reaches the block through a small register port with a write strobe and a combinational read port. A control register holds the two mode bits and three self-clearing commands:
- set the time from the staging registers;
- apply a signed offset from the staging registers;
- copy a staged frequency word into the active one.

A command is held pending for exactly one cycle. It takes effect on the following edge. While it is pending, the block reports busy. Reading the nanoseconds register captures the seconds value of the same instant into a shadow register, so that software gets a coherent pair.

Top module: `ptp_systime`

## Requirements
- R1: On synchronous reset the time, the phase accumulator, the active frequency word, the mode bits and all pending commands are zero, and busy is low.
- R2: With control bit 0 clear (coarse mode), the nanoseconds value grows by the step register on every clock that executes no set-time or offset command.
- R3: With control bit 0 set (fine mode), the active frequency word is added to a 32-bit accumulator each clock, and the step is added only on carry-out. A word of 2^31 adds the step once every two clocks, 2^30 once every four, and 0 never.
- R4: With control bit 1 set, nanoseconds wrap at 1,000,000,000, and the seconds value is incremented in the same cycle.
- R5: With control bit 1 clear, nanoseconds wrap at 2^31, and the seconds value is incremented in the same cycle.
- R6: Writing control bit 2 sets busy on the next edge. On the edge after that, the time is loaded from the staged seconds (address 2) and the staged nanoseconds (address 3, bits 30:0), no step is added, and the bit clears.
- R7: Writing control bit 3 adds the staged offset to the time on the second edge, with no step added. Bit 31 of the staged nanoseconds word selects subtraction. A subtraction is given as seconds 2^32 minus the amount and nanoseconds rollover minus the amount. The seconds result is then reduced by one unless the nanosecond sum wraps.
- R8: Writing control bit 4 copies the staged frequency word (address 4) into the active word on the second edge, after which the bit clears.
- R9: The step register (address 1) is 8 bits. A written value above 255 is stored as 255.
- R10: A control write whose command bits arrive while a command is pending is ignored. When several command bits are written at once, only one runs, with set-time first, then offset, then frequency load. Control read bits 4:2 show the pending command and bit 5 shows busy.
- R11: Reading address 5 returns nanoseconds and captures the seconds of that same cycle into a shadow that address 6 returns. Address 7 returns the live seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PTP reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; with address 5 it captures the shadow seconds |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| sys_sec | output | 32 | Current seconds |
| sys_ns | output | 31 | Current nanoseconds |
| busy | output | 1 | A command is pending |

## Verification
The assertions watch every cycle for the following:
- at most one command is pending, and it is gone one cycle later;
- nanoseconds stay below the rollover once they are in range;
- outside commands, seconds never move by more than one;
- the time moves whenever a nonzero step is applied;
- the accumulator is frozen in coarse mode;
- a frequency load lands one edge after it runs.

Only the bench scenarios can show the following:
- the exact carry cadence for a given frequency word;
- the wrap points in both formats;
- the arithmetic of complement-encoded subtraction, including the borrow case;
- command priority and the discarding of a command written while busy;
- clamping of the step register;
- agreement between the shadow seconds and the nanoseconds read across a seconds rollover.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;

    localparam int SEC_W  = 32;
    localparam int NS_W   = 31;
    localparam int ACC_W  = 32;
    localparam int INC_W  = 8;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    // control register bit positions
    localparam int CTL_FINE = 0;
    localparam int CTL_DEC  = 1;
    localparam int CTL_SET  = 2;
    localparam int CTL_OFS  = 3;
    localparam int CTL_FRQ  = 4;
    localparam int CTL_BUSY = 5;
    localparam int OFS_SUB_BIT = 31;

    localparam logic [NS_W:0] ROLL_DEC = (NS_W+1)'(1000000000);
    localparam logic [NS_W:0] ROLL_BIN = (NS_W+1)'(1) << NS_W;
    localparam logic [INC_W-1:0] INC_MAX = {INC_W{1'b1}};

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL      = 3'd0,
        RA_STEP      = 3'd1,
        RA_STG_SEC   = 3'd2,
        RA_STG_NS    = 3'd3,
        RA_STG_FREQ  = 3'd4,
        RA_NS_SNAP   = 3'd5,
        RA_SEC_SHDW  = 3'd6,
        RA_SEC_LIVE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic load_freq;
        logic add_offset;
        logic set_time;
    } cmd_t;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    typedef struct packed {
        logic [NS_W-1:0] ns;
        logic            carry;
    } ns_sum_t;

    function automatic logic [NS_W:0] rollover_of(input logic dec);
        return dec ? ROLL_DEC : ROLL_BIN;
    endfunction

    function automatic ns_sum_t ns_wrap_add(input logic [NS_W-1:0] base,
                                            input logic [NS_W:0]   addv,
                                            input logic [NS_W:0]   roll);
        logic [NS_W:0] s;
        ns_sum_t r;
        s = {1'b0, base} + addv;
        r.carry = (s >= roll);
        if (r.carry) s = s - roll;
        r.ns = s[NS_W-1:0];
        return r;
    endfunction

    function automatic logic [INC_W-1:0] clamp_step(input logic [DATA_W-1:0] d);
        return (d > DATA_W'(INC_MAX)) ? INC_MAX : d[INC_W-1:0];
    endfunction

endpackage

// File: rtl/ptp_cmd_unit.sv
module ptp_cmd_unit
    import ptp_systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTL_FRQ:0]  ctrl_bits,
    output logic              fine_mode,
    output logic              dec_mode,
    output cmd_t              pend,
    output logic              busy
);
    cmd_t pend_q, pick;
    logic fine_q, dec_q;

    always_comb begin
        pick = '0;
        if (ctrl_bits[CTL_SET])      pick.set_time   = 1'b1;
        else if (ctrl_bits[CTL_OFS]) pick.add_offset = 1'b1;
        else if (ctrl_bits[CTL_FRQ]) pick.load_freq  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            fine_q <= 1'b0;
            dec_q  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                fine_q <= ctrl_bits[CTL_FINE];
                dec_q  <= ctrl_bits[CTL_DEC];
            end
            if (pend_q != '0)  pend_q <= '0;
            else if (ctrl_wr)  pend_q <= pick;
        end
    end

    assign fine_mode = fine_q;
    assign dec_mode  = dec_q;
    assign pend      = pend_q;
    assign busy      = (pend_q != '0);

    // R10: a single command at a time
    a_r10_single_cmd: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pend_q));
    // R6: a pending command clears itself after one cycle, new writes ignored
    a_r6_self_clear: assert property (@(posedge clk) disable iff (rst)
        busy |=> (pend_q == '0));
endmodule

// File: rtl/ptp_rate_acc.sv
module ptp_rate_acc
    import ptp_systime_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fine_mode,
    input  logic             load_freq,
    input  logic [ACC_W-1:0] staged_freq,
    output logic             tick
);
    logic [ACC_W-1:0] acc_q, freq_q;
    logic [ACC_W:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, freq_q};
    assign tick    = fine_mode ? acc_sum[ACC_W] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            freq_q <= '0;
        end else begin
            if (fine_mode) acc_q <= acc_sum[ACC_W-1:0];
            if (load_freq) freq_q <= staged_freq;
        end
    end

    // R8: the staged word becomes active one edge after the load runs
    a_r8_freq_load: assert property (@(posedge clk) disable iff (rst)
        load_freq |=> (freq_q == $past(staged_freq)));
    // R3: the phase accumulator only moves in fine mode
    a_r3_coarse_hold: assert property (@(posedge clk) disable iff (rst)
        !fine_mode |=> $stable(acc_q));
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_mode,
    input  logic              tick,
    input  cmd_t              pend,
    input  logic [SEC_W-1:0]  stg_sec,
    input  logic [DATA_W-1:0] stg_ns_word,
    input  logic [INC_W-1:0]  step,
    output tod_t              tod
);
    tod_t          tod_q, tod_d;
    logic [NS_W:0] roll;
    ns_sum_t       step_sum, ofs_sum;
    logic          sub_req;

    always_comb begin
        roll     = rollover_of(dec_mode);
        sub_req  = stg_ns_word[OFS_SUB_BIT];
        ofs_sum  = ns_wrap_add(tod_q.ns, {1'b0, stg_ns_word[NS_W-1:0]}, roll);
        step_sum = ns_wrap_add(tod_q.ns, (NS_W+1)'(step), roll);
        tod_d    = tod_q;
        if (pend.set_time) begin
            tod_d.sec = stg_sec;
            tod_d.ns  = stg_ns_word[NS_W-1:0];
        end else if (pend.add_offset) begin
            tod_d.ns  = ofs_sum.ns;
            tod_d.sec = tod_q.sec + stg_sec + SEC_W'(ofs_sum.carry) - SEC_W'(sub_req);
        end else if (tick) begin
            tod_d.ns  = step_sum.ns;
            tod_d.sec = tod_q.sec + SEC_W'(step_sum.carry);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tod_q <= '0;
        else     tod_q <= tod_d;
    end

    assign tod = tod_q;

    // R4/R5: nanoseconds stay below the selected rollover once in range
    a_r4_ns_in_range: assert property (@(posedge clk) disable iff (rst)
        (({1'b0, tod_q.ns} < roll) && !pend.set_time &&
         (!pend.add_offset || ({1'b0, stg_ns_word[NS_W-1:0]} < roll)))
        |=> ({1'b0, tod_q.ns} < $past(roll)));
    // R5: outside commands seconds advance by at most one
    a_r5_sec_step: assert property (@(posedge clk) disable iff (rst)
        (!pend.set_time && !pend.add_offset)
        |=> ((tod_q.sec - $past(tod_q.sec)) <= SEC_W'(1)));
    // R2: a nonzero applied step always moves the time
    a_r2_time_moves: assert property (@(posedge clk) disable iff (rst)
        (tick && (step != '0) && !pend.set_time && !pend.add_offset)
        |=> (tod_q != $past(tod_q)));
endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
    import ptp_systime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEC_W-1:0]  sys_sec,
    output logic [NS_W-1:0]   sys_ns,
    output logic              busy
);
    logic [INC_W-1:0]  step_q;
    logic [SEC_W-1:0]  stg_sec_q, shadow_q;
    logic [DATA_W-1:0] stg_ns_q;
    logic [ACC_W-1:0]  stg_freq_q;
    logic              fine_mode, dec_mode, tick, busy_w, ctrl_wr;
    cmd_t              pend;
    tod_t              tod;

    assign ctrl_wr = wr_en && (reg_addr_e'(wr_addr) == RA_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q     <= '0;
            stg_sec_q  <= '0;
            stg_ns_q   <= '0;
            stg_freq_q <= '0;
            shadow_q   <= '0;
        end else begin
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    RA_STEP:     step_q     <= clamp_step(wr_data);
                    RA_STG_SEC:  stg_sec_q  <= wr_data[SEC_W-1:0];
                    RA_STG_NS:   stg_ns_q   <= wr_data;
                    RA_STG_FREQ: stg_freq_q <= wr_data[ACC_W-1:0];
                    default: ;
                endcase
            end
            if (rd_en && (reg_addr_e'(rd_addr) == RA_NS_SNAP))
                shadow_q <= tod.sec;
        end
    end

    ptp_cmd_unit u_cmd (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (wr_data[CTL_FRQ:0]),
        .fine_mode (fine_mode),
        .dec_mode  (dec_mode),
        .pend      (pend),
        .busy      (busy_w)
    );

    ptp_rate_acc u_rate (
        .clk         (clk),
        .rst         (rst),
        .fine_mode   (fine_mode),
        .load_freq   (pend.load_freq),
        .staged_freq (stg_freq_q),
        .tick        (tick)
    );

    ptp_time_core u_core (
        .clk         (clk),
        .rst         (rst),
        .dec_mode    (dec_mode),
        .tick        (tick),
        .pend        (pend),
        .stg_sec     (stg_sec_q),
        .stg_ns_word (stg_ns_q),
        .step        (step_q),
        .tod         (tod)
    );

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            RA_CTRL: begin
                rd_data[CTL_FINE] = fine_mode;
                rd_data[CTL_DEC]  = dec_mode;
                rd_data[CTL_SET]  = pend.set_time;
                rd_data[CTL_OFS]  = pend.add_offset;
                rd_data[CTL_FRQ]  = pend.load_freq;
                rd_data[CTL_BUSY] = busy_w;
            end
            RA_STEP:     rd_data = DATA_W'(step_q);
            RA_STG_SEC:  rd_data = DATA_W'(stg_sec_q);
            RA_STG_NS:   rd_data = stg_ns_q;
            RA_STG_FREQ: rd_data = DATA_W'(stg_freq_q);
            RA_NS_SNAP:  rd_data = DATA_W'(tod.ns);
            RA_SEC_SHDW: rd_data = DATA_W'(shadow_q);
            RA_SEC_LIVE: rd_data = DATA_W'(tod.sec);
            default: ;
        endcase
    end

    assign sys_sec = tod.sec;
    assign sys_ns  = tod.ns;
    assign busy    = busy_w;
endmodule

// File: tb/test_ptp_systime.sv
module test_ptp_systime;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] sys_sec;
    logic [30:0] sys_ns;
    logic        busy;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    bit    live_cmp = 0;
    string cur_req = "R1";

    localparam logic [31:0] C_FINE = 32'h1, C_DEC = 32'h2, C_SET = 32'h4,
                            C_OFS = 32'h8, C_FRQ = 32'h10;

    always #2 clk = ~clk;

    ptp_systime i_ptp_systime (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_sec(sys_sec), .sys_ns(sys_ns), .busy(busy)
    );

    // behavioural reference
    longint m_sec, m_ns, m_acc, m_frq, m_stg_frq, m_stg_sec, m_stg_ns, m_shadow;
    longint m_roll, m_sum, m_wrap, m_tick, m_nacc;
    int     m_step, m_pend;
    bit     m_fine, m_dec;

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_ns = 0; m_acc = 0; m_frq = 0; m_stg_frq = 0;
            m_stg_sec = 0; m_stg_ns = 0; m_shadow = 0; m_step = 0;
            m_pend = 0; m_fine = 0; m_dec = 0;
        end else begin
            m_roll = m_dec ? 64'd1000000000 : 64'd2147483648;
            if (rd_en && rd_addr == 3'd5) m_shadow = m_sec;
            if (m_fine) begin
                m_sum  = m_acc + m_frq;
                m_tick = (m_sum >= 64'd4294967296) ? 1 : 0;
                m_nacc = m_sum % 64'd4294967296;
            end else begin
                m_tick = 1;
                m_nacc = m_acc;
            end
            if (m_pend == 1) begin
                m_sec = m_stg_sec;
                m_ns  = m_stg_ns & 64'h7FFFFFFF;
            end else if (m_pend == 2) begin
                m_sum  = m_ns + (m_stg_ns & 64'h7FFFFFFF);
                m_wrap = (m_sum >= m_roll) ? 1 : 0;
                m_ns   = m_wrap != 0 ? m_sum - m_roll : m_sum;
                m_sec  = (m_sec + m_stg_sec + m_wrap - ((m_stg_ns >> 31) & 1)) & 64'hFFFFFFFF;
            end else if (m_tick != 0) begin
                m_sum  = m_ns + m_step;
                m_wrap = (m_sum >= m_roll) ? 1 : 0;
                m_ns   = m_wrap != 0 ? m_sum - m_roll : m_sum;
                m_sec  = (m_sec + m_wrap) & 64'hFFFFFFFF;
            end
            if (m_pend == 3) m_frq = m_stg_frq;
            m_acc = m_nacc;
            if (m_pend != 0) m_pend = 0;
            else if (wr_en && wr_addr == 3'd0) begin
                if (wr_data[2])      m_pend = 1;
                else if (wr_data[3]) m_pend = 2;
                else if (wr_data[4]) m_pend = 3;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_fine = wr_data[0]; m_dec = wr_data[1]; end
                    3'd1: m_step = (wr_data > 32'd255) ? 255 : int'(wr_data);
                    3'd2: m_stg_sec = longint'(wr_data);
                    3'd3: m_stg_ns  = longint'(wr_data);
                    3'd4: m_stg_frq = longint'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live_cmp && !rst)
            chk(cur_req, {sys_sec, sys_ns, busy},
                {m_sec[31:0], m_ns[30:0], (m_pend != 0)});
    end

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] ns_ref, sec_ref;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        live_cmp = 1'b1;
        // R1: reset state
        chk("R1", {sys_sec, sys_ns, busy}, 64'd0);
        rd_addr = 3'd0; #1;
        chk("R1", 64'(rd_data), 64'd0);
        @(negedge clk);

        // R9: step clamp
        cur_req = "R9";
        wr(3'd1, 32'd300);
        rd_addr = 3'd1; #1;
        chk("R9", 64'(rd_data), 64'd255);
        @(negedge clk);
        wr(3'd1, 32'd20);

        // R2: coarse stepping in binary format
        cur_req = "R2";
        idle(3);
        ns_ref = 32'(sys_ns);
        idle(5);
        chk("R2", 64'(sys_ns) - 64'(ns_ref), 64'd100);

        // R6 and R5: set time near binary rollover
        cur_req = "R5";
        wr(3'd2, 32'd7);
        wr(3'd3, 32'h7FFF_FFF6);
        wr(3'd0, C_SET);
        chk("R10", 64'(busy), 64'd1);
        rd_addr = 3'd0; #1;
        chk("R10", 64'(rd_data), 64'h24);
        idle(1);
        chk("R6", {sys_sec, sys_ns, busy}, {32'd7, 31'h7FFF_FFF6, 1'b0});
        idle(1);
        chk("R5", {sys_sec, sys_ns, busy}, {32'd8, 31'd10, 1'b0});

        // R4: decimal rollover
        cur_req = "R4";
        wr(3'd2, 32'd9);
        wr(3'd3, 32'd999_999_990);
        wr(3'd0, C_DEC | C_SET);
        idle(1);
        chk("R4", {sys_sec, sys_ns, busy}, {32'd9, 31'd999_999_990, 1'b0});
        idle(1);
        chk("R4", {sys_sec, sys_ns, busy}, {32'd10, 31'd10, 1'b0});

        // R11: coherent snapshot across a seconds rollover
        cur_req = "R11";
        wr(3'd0, C_DEC | C_SET);
        idle(1);
        rd_en = 1'b1; rd_addr = 3'd5; #1;
        chk("R11", 64'(rd_data), 64'd999_999_990);
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 3'd6; #1;
        chk("R11", 64'(rd_data), 64'd9);
        rd_addr = 3'd7; #1;
        chk("R11", 64'(rd_data), 64'd10);
        @(negedge clk);

        // R6 / R7: set, add, subtract with time frozen (step 0)
        cur_req = "R7";
        wr(3'd1, 32'd0);
        wr(3'd2, 32'd100);
        wr(3'd3, 32'd600_000_000);
        wr(3'd0, C_DEC | C_SET);
        idle(1);
        chk("R6", {sys_sec, sys_ns}, {32'd100, 31'd600_000_000});
        wr(3'd2, 32'd3);
        wr(3'd3, 32'd500_000_000);
        wr(3'd0, C_DEC | C_OFS);
        idle(1);
        chk("R7", {sys_sec, sys_ns}, {32'd104, 31'd100_000_000});
        wr(3'd2, 32'hFFFF_FFFE);
        wr(3'd3, 32'h8000_0000 | 32'd300_000_000);
        wr(3'd0, C_DEC | C_OFS);
        idle(1);
        chk("R7", {sys_sec, sys_ns}, {32'd101, 31'd400_000_000});
        wr(3'd2, 32'd0);
        wr(3'd3, 32'h8000_0000 | 32'd500_000_000);
        wr(3'd0, C_DEC | C_OFS);
        idle(1);
        chk("R7", {sys_sec, sys_ns}, {32'd100, 31'd900_000_000});

        // R10: priority and ignore-while-busy
        cur_req = "R10";
        wr(3'd2, 32'd50);
        wr(3'd3, 32'd0);
        wr(3'd0, C_DEC | C_SET | C_OFS);
        wr(3'd0, C_DEC | C_OFS);
        chk("R10", {sys_sec, sys_ns, busy}, {32'd50, 31'd0, 1'b0});
        idle(2);
        chk("R10", {sys_sec, sys_ns, busy}, {32'd50, 31'd0, 1'b0});

        // R3 / R8: fine mode cadence
        cur_req = "R3";
        wr(3'd1, 32'd20);
        wr(3'd4, 32'h8000_0000);
        wr(3'd0, C_FINE | C_DEC | C_FRQ);
        idle(1);
        ns_ref = 32'(sys_ns);
        idle(10);
        chk("R8", 64'(sys_ns) - 64'(ns_ref), 64'd100);
        wr(3'd4, 32'h4000_0000);
        wr(3'd0, C_FINE | C_DEC | C_FRQ);
        idle(1);
        ns_ref = 32'(sys_ns);
        idle(8);
        chk("R3", 64'(sys_ns) - 64'(ns_ref), 64'd40);
        wr(3'd4, 32'd0);
        wr(3'd0, C_FINE | C_DEC | C_FRQ);
        idle(1);
        ns_ref = 32'(sys_ns);
        sec_ref = sys_sec;
        idle(6);
        chk("R3", {sys_sec, 1'b0, sys_ns}, {sec_ref, 1'b0, ns_ref[30:0]});

        live_cmp = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule